// File: doc/BRIEF.md
# Edge-Triggered Event Timestamp Capture

This block stamps external events with the value of a free-running counter that lives outside it. Two event sources come in: a dedicated input pin and the output of an analog comparator. A select input picks which one can trigger a capture. Each source is brought into the clock domain by a two-flop synchronizer. It then has its own edge detector, which compares the synchronized level with the sample taken one cycle earlier. A polarity input decides whether rising or falling transitions count as events.

When the selected source shows a transition of the configured polarity, the counter value present at that clock edge is loaded into a capture register. A capture flag is raised in the same clock edge. The flag, gated by an interrupt enable, drives an interrupt request. The flag stays up until one of two things happens: the interrupt is serviced (an acknowledge pulse), or software writes a one to the flag's bit through a write strobe with a data bit. A fresh capture always reloads the register, even if the flag is still up from an earlier event.

Top module: `evt_capture`

## Requirements
- R1: After reset, `stamp_o` is 0, `flag_o` is 0 and `irq_o` is 0.
- R2: With `src_sel_i` = 0 only `pin_i` can trigger a capture; with `src_sel_i` = 1 only `cmp_i` can. Transitions on the source that is not selected change neither `stamp_o` nor `flag_o`.
- R3: With `edge_sel_i` = 1 only a 0-to-1 transition of the selected source captures; with `edge_sel_i` = 0 only a 1-to-0 transition captures. The opposite transition leaves `stamp_o` and `flag_o` unchanged.
- R4: A level change applied to a source before clock edge k is captured at edge k+2, and `stamp_o` then holds the `count_i` value present at edge k+2. Without a capture, `stamp_o` holds its value.
- R5: `flag_o` rises in the same clock edge in which `stamp_o` is loaded by a capture.
- R6: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1.
- R7: A cycle with `irq_ack_i` = 1 and no capture clears `flag_o` at the next edge.
- R8: A cycle with `clr_wr_i` = 1 and `clr_wdata_i` = 1 and no capture clears `flag_o`; with `clr_wdata_i` = 0 the write leaves `flag_o` unchanged.
- R9: If a clear (acknowledge or write of one) and a capture fall in the same cycle, `flag_o` is 1 afterwards.
- R10: A capture reloads `stamp_o` with the current `count_i` even while `flag_o` is still 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 16 | Free-running counter value to be stamped |
| pin_i | input | 1 | Dedicated event pin (asynchronous) |
| cmp_i | input | 1 | Analog comparator output (asynchronous) |
| src_sel_i | input | 1 | Source select: 0 pin, 1 comparator |
| edge_sel_i | input | 1 | Polarity: 1 rising, 0 falling |
| irq_en_i | input | 1 | Interrupt enable |
| irq_ack_i | input | 1 | Interrupt serviced; clears the flag |
| clr_wr_i | input | 1 | Write strobe for the flag bit |
| clr_wdata_i | input | 1 | Written bit value; a one clears the flag |
| stamp_o | output | 16 | Capture register |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A capture and a clear of the flag can fall in the same clock cycle. The clear can come from the acknowledge or from a write of one. The bench provokes this by raising the clear inputs in the cycle that precedes the edge two cycles after the source transition, which is the edge at which the capture lands. It sweeps every mix of acknowledge, write strobe and write data against every source, polarity and transition. Each outcome is judged against a bench model in which a capture beats a clear, and the stamp must take the counter value of that same edge.

// File: rtl/evt_capture_pkg.sv
package evt_capture_pkg;

    localparam int CNT_W_DEF = 16;
    localparam int SYNC_STAGES_DEF = 2;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } pol_e;

    typedef struct packed {
        logic [CNT_W_DEF-1:0] stamp;
        logic                 flag;
    } cap_state_t;

endpackage

// File: rtl/evt_capture_sync.sv
module evt_capture_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[DEPTH-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[DEPTH-1];
endmodule

// File: rtl/evt_capture_edge.sv
module evt_capture_edge
    import evt_capture_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  pol_e pol,
    output logic hit
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
        unique case (pol)
            POL_RISE: hit = level & ~prev_q;
            default:  hit = ~level & prev_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/evt_capture_core.sv
module evt_capture_core
    import evt_capture_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [CNT_W_DEF-1:0] count,
    input  logic                 ack,
    input  logic                 wr,
    input  logic                 wdata,
    output logic [CNT_W_DEF-1:0] stamp,
    output logic                 flag
);
    cap_state_t st_d, st_q;
    logic       clear;

    always_comb begin
        st_d  = st_q;
        clear = ack | (wr & wdata);
        if (clear) st_d.flag = 1'b0;
        // a capture in the same cycle overrides any clear
        if (hit) begin
            st_d.stamp = count;
            st_d.flag  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stamp = st_q.stamp;
    assign flag  = st_q.flag;
endmodule

// File: rtl/evt_capture.sv
module evt_capture
    import evt_capture_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W_DEF-1:0] count_i,
    input  logic                 pin_i,
    input  logic                 cmp_i,
    input  logic                 src_sel_i,
    input  logic                 edge_sel_i,
    input  logic                 irq_en_i,
    input  logic                 irq_ack_i,
    input  logic                 clr_wr_i,
    input  logic                 clr_wdata_i,
    output logic [CNT_W_DEF-1:0] stamp_o,
    output logic                 flag_o,
    output logic                 irq_o
);
    localparam int NSRC = 2;

    logic [NSRC-1:0] raw_src;
    logic [NSRC-1:0] sync_src;
    logic [NSRC-1:0] src_hit;
    logic            cap_hit;
    pol_e            pol;

    assign raw_src = {cmp_i, pin_i};
    assign pol     = pol_e'(edge_sel_i);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        evt_capture_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_src[s]),
            .dout (sync_src[s])
        );
        evt_capture_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .level(sync_src[s]),
            .pol  (pol),
            .hit  (src_hit[s])
        );
    end

    assign cap_hit = src_hit[src_sel_i];

    evt_capture_core u_core (
        .clk  (clk),
        .rst_n(rst_n),
        .hit  (cap_hit),
        .count(count_i),
        .ack  (irq_ack_i),
        .wr   (clr_wr_i),
        .wdata(clr_wdata_i),
        .stamp(stamp_o),
        .flag (flag_o)
    );

    assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/evt_capture_chk.sv
module evt_capture_chk
    import evt_capture_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [CNT_W_DEF-1:0] count_i,
    input logic                 irq_en_i,
    input logic                 irq_ack_i,
    input logic                 clr_wr_i,
    input logic                 clr_wdata_i,
    input logic                 cap_hit,
    input logic [CNT_W_DEF-1:0] stamp_o,
    input logic                 flag_o,
    input logic                 irq_o
);
    a_r4_stamp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_hit |=> $stable(stamp_o));

    a_r5_flag_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(cap_hit));

    a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (flag_o && irq_en_i));

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && !cap_hit) |=> !flag_o);

    a_r8_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && clr_wr_i && !clr_wdata_i && !irq_ack_i) |=> flag_o);

    a_r9_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> flag_o);

    a_r10_stamp_reload: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> stamp_o == $past(count_i));
endmodule

bind evt_capture evt_capture_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_i    (count_i),
    .irq_en_i   (irq_en_i),
    .irq_ack_i  (irq_ack_i),
    .clr_wr_i   (clr_wr_i),
    .clr_wdata_i(clr_wdata_i),
    .cap_hit    (cap_hit),
    .stamp_o    (stamp_o),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
);

// File: tb/evt_capture_bench.sv
module evt_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] count_i = 16'h0000;
    logic        pin_i = 1'b0;
    logic        cmp_i = 1'b0;
    logic        src_sel_i = 1'b0;
    logic        edge_sel_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic        irq_ack_i = 1'b0;
    logic        clr_wr_i = 1'b0;
    logic        clr_wdata_i = 1'b0;
    logic [15:0] stamp_o;
    logic        flag_o;
    logic        irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] exp_stamp = 16'h0000;
    logic        exp_flag = 1'b0;

    always #4 clk = ~clk;

    evt_capture u_evt_capture (
        .clk(clk), .rst_n(rst_n), .count_i(count_i),
        .pin_i(pin_i), .cmp_i(cmp_i), .src_sel_i(src_sel_i),
        .edge_sel_i(edge_sel_i), .irq_en_i(irq_en_i),
        .irq_ack_i(irq_ack_i), .clr_wr_i(clr_wr_i),
        .clr_wdata_i(clr_wdata_i), .stamp_o(stamp_o),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One event on source src toward level lvl, with optional clears
    // raised in the cycle whose closing edge carries the capture.
    task automatic run_event(input bit src, input bit lvl,
                             input bit do_ack, input bit do_wr, input bit wd);
        logic        old;
        logic        hit;
        logic [15:0] capv;
        old = src ? cmp_i : pin_i;
        if (src) cmp_i = lvl; else pin_i = lvl;
        tick();
        count_i = count_i + 16'd1;
        tick();
        // no capture yet: latency of two edges (R4)
        chk(stamp_o == exp_stamp && flag_o == exp_flag, "R4 latency",
            {15'd0, flag_o, stamp_o}, {15'd0, exp_flag, exp_stamp});
        count_i = count_i + 16'd1;
        capv = count_i;
        irq_ack_i = do_ack;
        clr_wr_i = do_wr;
        clr_wdata_i = wd;
        tick();
        irq_ack_i = 1'b0;
        clr_wr_i = 1'b0;
        clr_wdata_i = 1'b0;
        hit = (src == src_sel_i) && (lvl != old) && (lvl == edge_sel_i);
        exp_flag = hit | (exp_flag & ~(do_ack | (do_wr & wd)));
        if (hit) exp_stamp = capv;
        chk(stamp_o == exp_stamp, "R2 R3 R4 R10 stamp", stamp_o, exp_stamp);
        chk(flag_o == exp_flag, "R5 R7 R8 R9 flag", flag_o, exp_flag);
        chk(irq_o == (exp_flag & irq_en_i), "R6 irq", irq_o, exp_flag & irq_en_i);
        count_i = count_i + 16'd37;
    endtask

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk(stamp_o == 16'h0 && flag_o == 1'b0 && irq_o == 1'b0, "R1 reset",
            {14'd0, irq_o, flag_o, stamp_o}, 32'd0);
        rst_n = 1'b1;
        irq_en_i = 1'b1;
        tick();
        tick();
        chk(flag_o == 1'b0 && irq_o == 1'b0, "R1 idle after reset",
            {30'd0, irq_o, flag_o}, 32'd0);
        count_i = 16'h1234;
        for (int clr = 0; clr < 8; clr++) begin
            for (int cfg = 0; cfg < 8; cfg++) begin
                src_sel_i = cfg[0];
                edge_sel_i = cfg[1];
                irq_en_i = cfg[2];
                tick();
                for (int k = 0; k < 4; k++) begin
                    bit src;
                    src = k[1];
                    run_event(src, src ? ~cmp_i : ~pin_i,
                              clr[0], clr[1], clr[2]);
                end
            end
        end
        // R8 write of zero against a raised flag
        src_sel_i = 1'b0;
        edge_sel_i = ~pin_i;
        tick();
        run_event(1'b0, ~pin_i, 1'b0, 1'b0, 1'b0);
        chk(flag_o == 1'b1, "R8 flag raised for zero write", flag_o, 1);
        clr_wr_i = 1'b1;
        clr_wdata_i = 1'b0;
        tick();
        clr_wr_i = 1'b0;
        chk(flag_o == 1'b1, "R8 zero write no effect", flag_o, 1);
        clr_wr_i = 1'b1;
        clr_wdata_i = 1'b1;
        tick();
        clr_wr_i = 1'b0;
        clr_wdata_i = 1'b0;
        exp_flag = 1'b0;
        chk(flag_o == 1'b0, "R8 one write clears", flag_o, 0);
        chk(stamp_o == exp_stamp, "R8 stamp untouched by clear", stamp_o, exp_stamp);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule